// File: doc/BRIEF.md
# Serial Die Identifier Reader

This block fetches the factory-set identifier of the die from an on-chip serial identifier register and presents it as one parallel word with a ready flag. The identifier register is a ring of `SRC_W` (90) bits. Only its leading `ID_W` (64) bits form the identifier; the trailing bits are reserved fuse values, and the block never places them in its output word.

Once reset is released, the block runs one read with no further request. It drives a serial clock and a shift/load control toward the register and samples the register's serial output. The register loads while the control is low and rotates one place per serial clock while it is high. After 64 captured bits and two settle/commit cycles, the whole word is copied to the output in one step and the ready flag rises.

From then on the serial clock is held low and nothing changes until the next reset. A later read happens only after reset returns the ready flag to low.

Top module: `die_id_reader`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `id_ready` = 0, `id_word` = 0 and `id_shift` = 0.
- R2: Count the rising edges since reset release, starting from 0 at the first edge with `rst_n` high. Before edge 0 `id_shift` is low, which is the load cycle. It is high after edges 0 to 63, exactly `ID_W` cycles. It is low from edge 64 onward.
- R3: The serial bit present in the first shift cycle lands in `id_word[0]`. Later bits fill rising bit positions, LSB first.
- R4: `id_word` equals the leading 64 bits of the source ring (source bits 0 to 63). The 26 reserved bits (source bits 64 to 89) appear nowhere in it.
- R5: `id_ready` rises after edge 66, which is the 67th edge after reset release (1 + `ID_W` + `SETTLE_CYC`), and not at any earlier edge.
- R6: While `id_ready` is low, `id_word` is zero. No partial identifier is ever visible.
- R7: While `id_ready` is high, `id_ready` stays high, `id_word` holds its value, `id_shift` is low and `id_sclk` stays low. Activity on `id_sdata` has no effect.
- R8: A reset during a read abandons it. After release, a new full read runs and captures the identifier currently in the source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; also the source of the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_sdata | input | 1 | Serial data from the identifier register |
| id_sclk | output | 1 | Serial clock to the register; a gated copy of `clk_i` until the read completes |
| id_shift | output | 1 | Register control: low = load, high = rotate one bit |
| id_word | output | ID_W | Captured identifier |
| id_ready | output | 1 | High once `id_word` holds the complete identifier |

## Verification
All results are due at fixed edges counted from reset release. `id_shift` follows the state one edge later. The word and `id_ready` change together only at edge 66. The reset values are due one edge after `rst_n` is sampled low.

The bench keeps its own edge counter and derives the expected shift control, ready flag and word for every cycle from that count. It compares them at the falling edge, half a period after the register updates.

The hold behaviour and the reset-during-read case are checked explicitly. The no-effect check drives noise on the serial input after completion and compares the output word at the same falling-edge sample points.

// File: rtl/die_id_pkg.sv
// Package: shared types for the die identifier reader.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package die_id_pkg;

    // Read sequencer states, in the order they are visited.
    typedef enum logic [2:0] {
        ST_LOAD   = 3'd0,
        ST_SHIFT  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_COMMIT = 3'd3,
        ST_DONE   = 3'd4
    } rd_state_t;

endpackage

// File: rtl/die_id_seq.sv
// Module: die_id_seq
// Sequences one identifier read: one load cycle, ID_W shift cycles,
// SETTLE_CYC-1 settle cycles and one commit cycle, then parks in DONE.
// Assumes SETTLE_CYC >= 2 and a synchronous active-low reset.
module die_id_seq
    import die_id_pkg::*;
#(
    parameter int ID_W       = 64,
    parameter int SETTLE_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    output logic shift_en,
    output logic commit,
    output logic running
);
    localparam int CNT_W     = $clog2(ID_W + SETTLE_CYC + 1);
    localparam int SHIFT_END = ID_W - 1;
    localparam int SETL_END  = (SETTLE_CYC >= 2) ? SETTLE_CYC - 2 : 0;

    rd_state_t        state_q;
    rd_state_t        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next-state and counter logic for the read sequence.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOAD: begin
                state_d = ST_SHIFT;
                cnt_d   = '0;
            end
            ST_SHIFT: begin
                if (cnt_q == CNT_W'(SHIFT_END)) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == CNT_W'(SETL_END)) begin
                    state_d = ST_COMMIT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_COMMIT: state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_LOAD;
        endcase
    end

    // State and counter registers, cleared by reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Decoded controls for the datapath and the serial interface.
    always_comb begin
        shift_en = (state_q == ST_SHIFT);
        commit   = (state_q == ST_COMMIT);
        running  = (state_q != ST_DONE);
    end

endmodule

// File: rtl/die_id_deser.sv
// Module: die_id_deser
// Deserialiser: captures one serial bit per enabled cycle, LSB first,
// so that the first bit ends in bit 0 after ID_W captures.
// Assumes the serial bit is stable around the rising edge of clk_i.
module die_id_deser #(
    parameter int ID_W = 64
) (
    input  logic            clk_i,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic            sdata,
    output logic [ID_W-1:0] shreg
);
    // Shift new bits in at the top so earlier bits move toward bit 0.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (cap_en) begin
            shreg <= {sdata, shreg[ID_W-1:1]};
        end
    end

endmodule

// File: rtl/die_id_hold.sv
// Module: die_id_hold
// Output holding register: copies the deserialised word in one edge on
// commit and raises the ready flag at that same edge; holds until reset.
// Assumes commit pulses once per read.
module die_id_hold #(
    parameter int ID_W = 64
) (
    input  logic            clk_i,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [ID_W-1:0] shreg,
    output logic [ID_W-1:0] word_q,
    output logic            ready_q
);
    // Single-step publish of the complete word with its ready flag.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            word_q  <= '0;
            ready_q <= 1'b0;
        end else if (commit && !ready_q) begin
            word_q  <= shreg;
            ready_q <= 1'b1;
        end
    end

endmodule

// File: rtl/die_id_reader.sv
// Module: die_id_reader (top)
// Reads the per-die identifier from a serial ring register once after
// reset and holds it. The serial clock is clk_i gated off after the read.
// Assumes the ring register loads on a serial clock edge with the shift
// control low and rotates toward its output with it high.
module die_id_reader #(
    parameter int ID_W       = 64,
    parameter int SETTLE_CYC = 2
) (
    input  logic            clk_i,
    input  logic            rst_n,
    input  logic            id_sdata,
    output logic            id_sclk,
    output logic            id_shift,
    output logic [ID_W-1:0] id_word,
    output logic            id_ready
);
    logic            shift_en;
    logic            commit;
    logic            running;
    logic [ID_W-1:0] shreg;

    die_id_seq #(.ID_W(ID_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk_i    (clk_i),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .commit   (commit),
        .running  (running)
    );

    die_id_deser #(.ID_W(ID_W)) u_deser (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .cap_en (shift_en),
        .sdata  (id_sdata),
        .shreg  (shreg)
    );

    die_id_hold #(.ID_W(ID_W)) u_hold (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .commit  (commit),
        .shreg   (shreg),
        .word_q  (id_word),
        .ready_q (id_ready)
    );

    // Serial interface drive: gated clock and shift/load control.
    always_comb begin
        id_sclk  = clk_i & running;
        id_shift = shift_en;
    end

endmodule

// File: rtl/die_id_reader_chk.sv
// Module: die_id_reader_chk
// Assertion checker bound to die_id_reader. Counts edges since reset
// release to check the ready latency without deep $past.
module die_id_reader_chk #(
    parameter int ID_W       = 64,
    parameter int SETTLE_CYC = 2
) (
    input logic            clk_i,
    input logic            rst_n,
    input logic            id_shift,
    input logic [ID_W-1:0] id_word,
    input logic            id_ready
);
    localparam int LAT = 1 + ID_W + SETTLE_CYC;

    logic [15:0] edge_cnt;

    // Edges seen since reset release, saturating.
    always_ff @(posedge clk_i) begin
        if (!rst_n)
            edge_cnt <= '0;
        else if (edge_cnt != 16'hFFFF)
            edge_cnt <= edge_cnt + 16'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        !rst_n |=> (!id_ready && id_word == '0 && !id_shift)); // R1

    AST_READY_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(id_ready) |-> (edge_cnt == 16'(LAT))); // R5

    AST_NO_PARTIAL_WORD: assert property (@(posedge clk_i) disable iff (!rst_n)
        !id_ready |-> (id_word == '0)); // R6

    AST_HOLD_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_n)
        id_ready |=> (id_ready && $stable(id_word))); // R7

    AST_NO_SHIFT_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_n)
        id_ready |-> !id_shift); // R7

endmodule

bind die_id_reader die_id_reader_chk #(.ID_W(ID_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .id_shift (id_shift),
    .id_word  (id_word),
    .id_ready (id_ready)
);

// File: tb/sim_die_id_reader.sv
`timescale 1ns/1ps
module sim_die_id_reader;
    localparam int ID_W  = 64;
    localparam int SRC_W = 90;
    localparam int LAT   = 67;

    logic             clk_i = 1'b0;
    logic             rst_n = 1'b0;
    logic             id_sdata;
    logic             id_sclk;
    logic             id_shift;
    logic [ID_W-1:0]  id_word;
    logic             id_ready;

    logic [SRC_W-1:0] src_val = '0;
    logic [SRC_W-1:0] ring;
    logic             noise_on = 1'b0;
    logic             noise_bit = 1'b0;
    int               cyc = 0;
    int               n_run = 0;
    int               n_fail = 0;

    always #2.5 clk_i = ~clk_i;

    die_id_reader u0 (
        .clk_i(clk_i), .rst_n(rst_n), .id_sdata(id_sdata), .id_sclk(id_sclk),
        .id_shift(id_shift), .id_word(id_word), .id_ready(id_ready)
    );

    // Behavioural ring register: load when shift low, rotate toward bit 0 when high.
    always @(posedge id_sclk) begin
        if (!id_shift) ring <= src_val;
        else           ring <= {ring[0], ring[SRC_W-1:1]};
    end
    assign id_sdata = noise_on ? noise_bit : ring[0];

    // Bench edge count since reset release.
    always @(posedge clk_i) cyc <= rst_n ? cyc + 1 : 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [ID_W-1:0] act, input logic [ID_W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-cycle reference comparison at the falling edge.
    task automatic run(input int n, input logic [ID_W-1:0] exp_id);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            begin
                logic e_shift, e_ready;
                logic [ID_W-1:0] e_word;
                e_shift = (cyc >= 1 && cyc <= ID_W);
                e_ready = (cyc >= LAT);
                e_word  = e_ready ? exp_id : '0;
                check(id_shift == e_shift, "R2", "id_shift", ID_W'(id_shift), ID_W'(e_shift));
                check(id_ready == e_ready, "R5", "id_ready", ID_W'(id_ready), ID_W'(e_ready));
                check(id_word == e_word, e_ready ? "R4" : "R6", "id_word", id_word, e_word);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [ID_W-1:0] held;
        // R1: reset state
        src_val = {26'h3FFFFFF, 64'h0123_4567_89AB_CDEF};
        repeat (3) @(negedge clk_i);
        check(!id_ready && id_word == '0 && !id_shift, "R1", "reset outputs",
              {id_word[ID_W-3:0], id_ready, id_shift}, '0);
        rst_n = 1'b1;
        // R2 R5 R6 R4: reserved bits all ones, leading 64 only
        run(80, src_val[ID_W-1:0]);
        check(id_word[0] == 1'b1 && id_word[ID_W-1] == 1'b0, "R3", "lsb first",
              id_word, src_val[ID_W-1:0]);
        // R7: noise on serial input after completion
        held = id_word;
        noise_on = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk_i); #1;
            check(id_sclk == 1'b0, "R7", "sclk parked", ID_W'(id_sclk), '0);
            noise_bit = ~noise_bit;
            @(negedge clk_i);
            check(id_word == held && id_ready, "R7", "hold", id_word, held);
        end
        noise_on = 1'b0;
        // R8: reset mid-read, new source value
        @(negedge clk_i); rst_n = 1'b0;
        @(negedge clk_i);
        check(!id_ready && id_word == '0, "R1", "reset after done", id_word, '0);
        rst_n = 1'b1;
        src_val = {26'h1555555, 64'hFFFF_FFFF_FFFF_FFFE};
        run(30, src_val[ID_W-1:0]);
        rst_n = 1'b0;
        @(negedge clk_i);
        check(!id_ready && id_word == '0, "R8", "abort clears", id_word, '0);
        src_val = {26'h0AAAAAA, 64'hF00D_5A5A_C3C3_0001};
        rst_n = 1'b1;
        run(LAT - 1, src_val[ID_W-1:0]);
        check(!id_ready, "R5", "not ready at edge 66", ID_W'(id_ready), '0);
        run(5, src_val[ID_W-1:0]);
        check(id_word == src_val[ID_W-1:0] && id_ready, "R8", "new read",
              id_word, src_val[ID_W-1:0]);
        check(id_word[0] == src_val[0], "R3", "bit0", ID_W'(id_word[0]), ID_W'(src_val[0]));
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule